// File: doc/BRIEF.md
# Glitch-free two-input clock selector

This block picks one of two free-running clocks and passes it to a single clock output. Pulses are never shortened and no partial phase appears. Each input is qualified by a pair of lines, a select and an enable, and the input counts as requested only while both are high. When the request moves from one input to the other, the block first lets the present clock finish its active phase. It then parks the output at an idle level and hands over to the new clock only at that clock's own idle-going edge. Each branch carries its request across into its own clock through a two-stage synchronizer. That synchronizer runs on the edge that returns the clock to the idle level.

Parameters choose three things: which input drives the output straight out of reset, whether the idle level is low (falling-edge handover) or high (rising-edge handover), and a gating variant. In the gating variant the second input is replaced by a constant zero, so one control line turns a single clock on and off. Each input also has a bypass line. When the bypass of the active input is high and that input loses its request, the output leaves it at once, without waiting for an edge. Either line of a pair may serve as the control. Asynchronous control goes on the select line with the enable tied high. Control that meets setup and hold to the clock can go on the enable line instead.

Top module: `clk_sel2`

## Requirements
- R1: An input is requested only while both its select and its enable line are high; with the enable low, a high select has no effect.
- R2: In falling-edge mode (IDLE_HIGH=0), after the request leaves the active input the output keeps following that input until the input's next high-to-low edge, so a high phase in progress is not cut short.
- R3: In falling-edge mode a handover holds the output low until the new input has completed a high-to-low edge, so no output high or low phase is shorter than the shorter input half-period.
- R4: In rising-edge mode (IDLE_HIGH=1) the output is held high while idle or during a handover, and no output phase is shorter than the shorter input half-period.
- R5: With the bypass line of the active input high, removing that input's request drops it from the output immediately, without waiting for a clock edge.
- R6: While reset is high and directly after it, the input named by INIT_SEL (0 selects clk0, 1 selects clk1) drives the output with no settling delay.
- R7: When neither input is requested the output rests at the idle level, 0 for IDLE_HIGH=0 and 1 for IDLE_HIGH=1.
- R8: When both inputs are requested the input already driving the output keeps it; from idle, clk0 wins.
- R9: With GATE_MODE=1, lowering the clk0 request parks the output at 0, and raising it again brings clk0 back; the clk1 pins are ignored.
- R10: The two internal branch enables are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | First input clock |
| clk1 | input | 1 | Second input clock (ignored with GATE_MODE=1) |
| rst | input | 1 | Asynchronous active-high reset, loads the INIT_SEL choice |
| sel0 | input | 1 | Select line of input 0, may change asynchronously |
| en0 | input | 1 | Enable line of input 0, must meet timing to clk0 |
| byp0 | input | 1 | Immediate release of input 0 when its request drops |
| sel1 | input | 1 | Select line of input 1, may change asynchronously |
| en1 | input | 1 | Enable line of input 1, must meet timing to clk1 |
| byp1 | input | 1 | Immediate release of input 1 when its request drops |
| clk_out | output | 1 | Selected clock or idle level |

## Verification
The delicate case is a new request that arrives while the previous handover is still moving through the synchronizers. A release of one branch can then coincide with the start of the other, or both requests can rise together from idle. The bench drives two unrelated clocks (5 ns and 7 ns periods) and flips the requests at random intervals, often shorter than a full handover, and also asserts both at once. An edge monitor times every output phase against the 2.5 ns shorter half-period, and scoreboard items confirm which source the output follows once things settle.

// File: rtl/clk_sel2.sv
`timescale 1ns/10ps
module clk_sel2 #(
  parameter bit INIT_SEL  = 1'b0,
  parameter bit IDLE_HIGH = 1'b0,
  parameter bit GATE_MODE = 1'b0
) (
  input  logic clk0,
  input  logic clk1,
  input  logic rst,
  input  logic sel0,
  input  logic en0,
  input  logic byp0,
  input  logic sel1,
  input  logic en1,
  input  logic byp1,
  output logic clk_out
);

  logic clk1_i, ck0, ck1;
  logic want0, want1, cut0, cut1, hold0, hold1, ask0, ask1;
  logic sy0_a, sy0_b, sy1_a, sy1_b, on0, on1;

  assign clk1_i = GATE_MODE ? 1'b0 : clk1;
  assign ck0    = IDLE_HIGH ? clk0   : ~clk0;
  assign ck1    = IDLE_HIGH ? clk1_i : ~clk1_i;

  assign want0 = sel0 & en0;
  assign want1 = GATE_MODE ? ~want0 : (sel1 & en1);

  assign cut0  = byp0 & ~want0;
  assign cut1  = (GATE_MODE | byp1) & ~want1;

  assign hold0 = (sy0_a | sy0_b) & ~cut0;
  assign hold1 = (sy1_a | sy1_b) & ~cut1;

  assign ask0  = want0 & ~hold1;

  always_ff @(posedge ck0 or posedge rst) begin
    if (rst) begin
      sy0_a <= (INIT_SEL == 1'b0);
      sy0_b <= (INIT_SEL == 1'b0);
    end else begin
      sy0_a <= ask0;
      sy0_b <= sy0_a;
    end
  end

  generate
    if (GATE_MODE) begin : g_tied
      assign ask1  = want1 & ~hold0;
      assign sy1_a = 1'b0;
      assign sy1_b = ask1;
    end else begin : g_sync
      assign ask1 = want1 & ~hold0 & (~want0 | hold1);
      always_ff @(posedge ck1 or posedge rst) begin
        if (rst) begin
          sy1_a <= (INIT_SEL == 1'b1);
          sy1_b <= (INIT_SEL == 1'b1);
        end else begin
          sy1_a <= ask1;
          sy1_b <= sy1_a;
        end
      end
    end
  endgenerate

  assign on0 = sy0_b & ~cut0;
  assign on1 = sy1_b & ~cut1;

  assign clk_out = IDLE_HIGH ? ((clk0 | ~on0) & (clk1_i | ~on1))
                             : ((clk0 & on0) | (clk1_i & on1));

endmodule

// File: rtl/clk_sel2_chk.sv
`timescale 1ns/10ps
module clk_sel2_chk #(
  parameter bit INIT_SEL  = 1'b0,
  parameter bit IDLE_HIGH = 1'b0
) (
  input logic clk0,
  input logic clk1,
  input logic rst,
  input logic ck0,
  input logic clk_out,
  input logic on0,
  input logic on1,
  input logic sy0_a,
  input logic sy0_b
);

  p_excl_r10: assert property (@(posedge clk0) disable iff (rst)
    !(on0 && on1))
    else $error("both branch enables active");

  p_idle_r7: assert property (@(posedge clk1) disable iff (rst)
    (!on0 && !on1) |-> (clk_out == IDLE_HIGH))
    else $error("output not at idle level");

  p_sync_r3: assert property (@(posedge ck0) disable iff (rst)
    $rose(sy0_b) |-> $past(sy0_a))
    else $error("branch 0 enabled without passing first stage");

  p_reset_r6: assert property (@(posedge clk0)
    rst |-> (sy0_b == (INIT_SEL == 1'b0)))
    else $error("reset state does not match INIT_SEL");

endmodule

bind clk_sel2 clk_sel2_chk #(.INIT_SEL(INIT_SEL), .IDLE_HIGH(IDLE_HIGH)) u_chk (
  .clk0(clk0), .clk1(clk1), .rst(rst), .ck0(ck0), .clk_out(clk_out),
  .on0(on0), .on1(on1), .sy0_a(sy0_a), .sy0_b(sy0_b)
);

// File: tb/clk_sel2_test.sv
`timescale 1ns/10ps
module clk_sel2_test;
  logic clk0 = 1'b0, clk1 = 1'b0, rst = 1'b0;
  logic m_sel0 = 1'b1, m_en0 = 1'b1, m_byp0 = 1'b0;
  logic m_sel1 = 1'b0, m_en1 = 1'b1, m_byp1 = 1'b0;
  logic r_sel0 = 1'b0, r_sel1 = 1'b1;
  logic g_on = 1'b1;
  logic o_main, o_rise, o_gate;
  int checks = 0, errors = 0;
  bit mon_on = 1'b0, mon_busy = 1'b0;
  real lt_main = -1.0, lt_rise = -1.0;

  typedef struct { int dut; int src; string tag; } exp_t;
  exp_t sbq[$];

  always #2.5 clk0 = ~clk0;
  initial begin #0.2; forever #3.5 clk1 = ~clk1; end

  clk_sel2 uut (
    .clk0(clk0), .clk1(clk1), .rst(rst),
    .sel0(m_sel0), .en0(m_en0), .byp0(m_byp0),
    .sel1(m_sel1), .en1(m_en1), .byp1(m_byp1), .clk_out(o_main));

  clk_sel2 #(.INIT_SEL(1'b1), .IDLE_HIGH(1'b1)) u_rise (
    .clk0(clk0), .clk1(clk1), .rst(rst),
    .sel0(r_sel0), .en0(1'b1), .byp0(1'b0),
    .sel1(r_sel1), .en1(1'b1), .byp1(1'b0), .clk_out(o_rise));

  clk_sel2 #(.GATE_MODE(1'b1)) u_gate (
    .clk0(clk0), .clk1(clk1), .rst(rst),
    .sel0(g_on), .en0(1'b1), .byp0(1'b0),
    .sel1(1'b0), .en1(1'b0), .byp1(1'b0), .clk_out(o_gate));

  function automatic logic out_of(input int d);
    return (d == 0) ? o_main : (d == 1) ? o_rise : o_gate;
  endfunction

  function automatic logic exp_of(input int s);
    return (s == 0) ? clk0 : (s == 1) ? clk1 : (s == 3);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk0);
    #0.35;
  endtask

  task automatic chk(input bit ok, input string tag, input logic a, input logic e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, a, e);
    end
  endtask

  task automatic expect_src(input int d, input int s, input string tag);
    exp_t it;
    it.dut = d; it.src = s; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    wait (!mon_busy);
  endtask

  initial begin : monitor
    exp_t it;
    bit bad;
    logic a, e;
    forever begin
      wait (sbq.size() > 0);
      mon_busy = 1'b1;
      it = sbq.pop_front();
      bad = 1'b0; a = 1'b0; e = 1'b0;
      for (int n = 0; n < 20; n++) begin
        #1;
        if (!bad && out_of(it.dut) !== exp_of(it.src)) begin
          bad = 1'b1; a = out_of(it.dut); e = exp_of(it.src);
        end
      end
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s dut%0d src%0d got %0b expected %0b", it.tag, it.dut, it.src, a, e);
      end
      mon_busy = 1'b0;
    end
  end

  always @(o_main) begin
    if (mon_on) begin
      if (lt_main >= 0.0) begin
        checks++;
        if ($realtime - lt_main < 2.49) begin
          errors++;
          $display("FAIL R3 R10 phase got %0.2f ns expected >= 2.50", $realtime - lt_main);
        end
      end
      lt_main = $realtime;
    end
  end

  always @(o_rise) begin
    if (mon_on) begin
      if (lt_rise >= 0.0) begin
        checks++;
        if ($realtime - lt_rise < 2.49) begin
          errors++;
          $display("FAIL R4 phase got %0.2f ns expected >= 2.50", $realtime - lt_rise);
        end
      end
      lt_rise = $realtime;
    end
  end

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    #0.1 rst = 1'b1;
    tick(4);
    expect_src(0, 0, "R6 reset main");
    expect_src(1, 1, "R6 reset rise");
    rst = 1'b0;
    tick(1);
    expect_src(0, 0, "R6 after reset");
    lt_main = -1.0; lt_rise = -1.0; mon_on = 1'b1;
    expect_src(2, 0, "R9 gate on");

    m_sel0 = 1'b0; m_sel1 = 1'b1; tick(12);
    expect_src(0, 1, "R2 switch to clk1");
    m_en1 = 1'b0; tick(12);
    expect_src(0, 2, "R1 R7 enable low idles");
    m_en1 = 1'b1; tick(12);
    expect_src(0, 1, "R1 pair qualified");
    m_sel0 = 1'b1; tick(12);
    expect_src(0, 1, "R8 both keeps clk1");
    m_sel1 = 1'b0; tick(12);
    expect_src(0, 0, "R2 back to clk0");

    tick(1);
    m_sel0 = 1'b0; m_sel1 = 1'b1;
    #0.1;
    chk(o_main === 1'b1, "R2 high phase kept", o_main, 1'b1);
    tick(12);
    expect_src(0, 1, "R3 handover to clk1");
    m_sel1 = 1'b0; m_sel0 = 1'b1; tick(12);
    expect_src(0, 0, "R3 handover to clk0");

    mon_on = 1'b0;
    m_byp0 = 1'b1;
    tick(1);
    m_sel0 = 1'b0; m_sel1 = 1'b1;
    #0.1;
    chk(o_main === 1'b0, "R5 bypass immediate", o_main, 1'b0);
    tick(12);
    expect_src(0, 1, "R5 after bypass");
    m_byp0 = 1'b0;
    lt_main = -1.0; mon_on = 1'b1;

    r_sel1 = 1'b0; tick(12);
    expect_src(1, 3, "R7 R4 idle high");
    r_sel0 = 1'b1; tick(12);
    expect_src(1, 0, "R4 rise to clk0");

    g_on = 1'b0; tick(12);
    expect_src(2, 2, "R9 gate parks low");
    g_on = 1'b1; tick(12);
    expect_src(2, 0, "R9 gate resumes");

    m_sel0 = 1'b0; m_sel1 = 1'b0; r_sel0 = 1'b0; r_sel1 = 1'b0; tick(12);
    m_sel0 = 1'b1; m_sel1 = 1'b1; tick(12);
    expect_src(0, 0, "R8 tie from idle");

    for (int k = 0; k < 80; k++) begin
      case ($urandom_range(0, 3))
        0: begin m_sel0 = 1'b1; m_sel1 = 1'b0; end
        1: begin m_sel0 = 1'b0; m_sel1 = 1'b1; end
        2: begin m_sel0 = 1'b1; m_sel1 = 1'b1; end
        default: begin m_sel0 = 1'b0; m_sel1 = 1'b0; end
      endcase
      r_sel0 = m_sel0; r_sel1 = m_sel1;
      tick($urandom_range(1, 8));
    end

    m_sel0 = 1'b1; m_sel1 = 1'b0; r_sel0 = 1'b1; r_sel1 = 1'b0;
    tick(12);
    expect_src(0, 0, "R3 settle after random");
    expect_src(1, 0, "R4 settle after random");
    mon_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule